// File: doc/BRIEF.md
# Queued SPI Master with Per-Slave Chip Selects

This block is an SPI bus master that works through a list of queued transfers without processor help. Each queued entry names one of several slaves on a shared bus, gives a frame length in bits, and carries the transmit word. The engine asserts that slave's active-low select, waits a programmable settling time, clocks the frame, waits again, and then releases the select. Only after a further wait does it start the next entry. Each word received from the slave goes into its own receive queue.

Software drives the block through a four-address write port. Address 0 is the configuration: bits [3:0] set the guard delay in SCLK half-periods, where 0 acts as 1. Bit 4 selects clock mode 3 (1) or mode 0 (0). Bit 5 enables the interrupt. Address 1 stages the entry fields: bits [2:0] hold the select index and bits [8:4] hold the length code. A write to address 2 pushes one entry made of the staged fields and the written data. Address 3 is control: bit 0 sets the run enable (level), bit 1 clears the done flag and bit 2 clears the overflow flag. Received words are read from the head of the receive queue, whose head is visible before any read.

Frames may be any length from 4 to 32 bits, so parts that need odd clock counts (17 or 18 bits, for example) are served directly.

Top module: `spi_queue_master`

## Requirements
- R1: After reset every select is high, SCLK is low, MOSI is 0, and busy, done, overflow, irq, tx_full and rx_valid are all 0.
- R2: When run is enabled, entries are served in the order they were written, with no software action between them. While an entry is active, exactly `cs_n[sel]` is low. At all other times every select is high. No two selects are ever low together.
- R3: The transmit queue holds 8 entries and tx_full is 1 when it holds 8. A push while it is full is dropped and sets the overflow flag. That flag stays set until a control write with bit 2 set.
- R4: A length code c gives c+1 bits per frame, and codes 0 to 2 give 4 bits. A frame of n bits has exactly 2n SCLK edges inside its select window. This includes n = 17 and n = 18.
- R5: MOSI carries the low n bits of the entry data, most significant first. MOSI never changes at a rising SCLK edge. It is 0 once the select is released.
- R6: In mode 0, SCLK idles low. In mode 3, SCLK idles high. In both modes the first data bit is valid before the first rising edge, MISO is sampled on rising edges, and MOSI advances on falling edges.
- R7: With guard delay d (0 treated as 1), three intervals of d half-periods occur in order. The first separates select assertion from the first SCLK edge. The second separates the last edge from select release. The third follows release, before the engine can start the next entry one clock later.
- R10: One SCLK half-period lasts DIV clock cycles.
- R8: Received bits are shifted in most significant first and right-justified into a 32-bit word. The word is pushed at select release into an 8-entry receive queue whose head is shown on rx_data. While the receive queue is full, no new entry starts.
- R9: The done flag sets at the select release of an entry when no further entry is queued. A control write with bit 1 set clears it, and a set in the same cycle wins. irq is done while the interrupt is enabled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| rx_pop | input | 1 | Remove the receive queue head |
| rx_data | output | 32 | Receive queue head |
| rx_valid | output | 1 | Receive queue not empty |
| tx_full | output | 1 | Transmit queue holds 8 entries |
| busy | output | 1 | An entry is in progress |
| done | output | 1 | Queue finished flag |
| ovf | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low slave selects |

## Verification
A register write becomes visible on the flags and queue outputs after the next clock edge. An entry that is able to start asserts its select on the first edge at which it is both queued and run-enabled. Every later SCLK edge, MOSI change, select release and receive push falls a whole number of DIV-cycle ticks after that start: at d, at d+2n-1 and at 2d+2n-1 ticks. The bench model keeps its own count of cycles since each start and derives the pin levels from those tick counts. It compares every output on the falling clock edge, half a cycle after the registers settle. Separate window monitors count the SCLK edges per select window and the cycles from select assertion to the first edge. These monitors check those counts against the entry's own length and delay.

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int NSEL  = 8,
  parameter int DEPTH = 8,
  parameter int DIV   = 2,
  parameter int DW    = 32,
  parameter int LENW  = 5,
  parameter int DLYW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rx_pop,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  output logic            tx_full,
  output logic            busy,
  output logic            done,
  output logic            ovf,
  output logic            irq,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSEL-1:0] cs_n
);
  localparam int SELW = $clog2(NSEL);
  localparam int PW   = $clog2(DEPTH);
  localparam int NW   = LENW + 1;
  localparam int TW   = DLYW + NW + 1;
  localparam int DVW  = $clog2(DIV + 1);
  localparam int EW   = SELW + LENW + DW;

  logic [DLYW-1:0] cfg_dly;
  logic            cfg_mode3, cfg_irqen, run_en;
  logic [SELW-1:0] stg_sel;
  logic [LENW-1:0] stg_len;

  logic [EW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [PW:0]   twp, trp, rwp, rrp, tcnt, rcnt;
  logic          tx_empty, rx_full;

  assign tcnt     = twp - trp;
  assign rcnt     = rwp - rrp;
  assign tx_empty = (tcnt == '0);
  assign tx_full  = (tcnt == (PW+1)'(DEPTH));
  assign rx_full  = (rcnt == (PW+1)'(DEPTH));
  assign rx_valid = (rcnt != '0);
  assign rx_data  = rxm[rrp[PW-1:0]];

  logic [SELW-1:0] hd_sel;
  logic [LENW-1:0] hd_len;
  logic [DW-1:0]   hd_dat;
  logic [NW-1:0]   hd_n, hd_sh;
  assign {hd_sel, hd_len, hd_dat} = txm[trp[PW-1:0]];
  assign hd_n  = (hd_len < LENW'(3)) ? NW'(4) : NW'(hd_len) + NW'(1);
  assign hd_sh = NW'(DW) - hd_n;

  logic [SELW-1:0] e_sel;
  logic [DLYW-1:0] e_dly;
  logic [NW-1:0]   e_n;
  logic            sclk_q;
  logic [DW-1:0]   tx_sh, rx_sh;
  logic [TW-1:0]   t, tn, dly_t, n2_t, rel_t, fin_t;
  logic [DVW-1:0]  dv;
  logic            tick, edge_hit, first_edge, rel_hit, fin_hit, start, wr_push;

  assign wr_push    = wr_en && (wr_addr == 2'd2);
  assign start      = !busy && run_en && !tx_empty && !rx_full;
  assign tick       = (dv == DVW'(DIV - 1));
  assign tn         = t + TW'(1);
  assign dly_t      = TW'(e_dly);
  assign n2_t       = TW'(e_n) << 1;
  assign rel_t      = (dly_t << 1) + n2_t - TW'(1);
  assign fin_t      = rel_t + dly_t;
  assign edge_hit   = busy && tick && (tn >= dly_t) && (tn < dly_t + n2_t);
  assign first_edge = (tn == dly_t);
  assign rel_hit    = busy && tick && (tn == rel_t);
  assign fin_hit    = busy && tick && (tn == fin_t);

  assign sclk = busy ? sclk_q : cfg_mode3;
  assign mosi = tx_sh[DW-1];
  assign irq  = done && cfg_irqen;

  always_ff @(posedge clk) begin
    if (wr_push && !tx_full) txm[twp[PW-1:0]] <= {stg_sel, stg_len, wr_data};
    if (rel_hit) rxm[rwp[PW-1:0]] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_dly <= '0; cfg_mode3 <= 1'b0; cfg_irqen <= 1'b0; run_en <= 1'b0;
      stg_sel <= '0; stg_len <= '0;
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
      busy <= 1'b0; done <= 1'b0; ovf <= 1'b0;
      e_sel <= '0; e_dly <= '0; e_n <= '0; sclk_q <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; t <= '0; dv <= '0;
      cs_n <= '1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            cfg_dly   <= wr_data[DLYW-1:0];
            cfg_mode3 <= wr_data[4];
            cfg_irqen <= wr_data[5];
          end
          2'd1: begin
            stg_sel <= wr_data[SELW-1:0];
            stg_len <= wr_data[4 +: LENW];
          end
          2'd2: begin
            if (tx_full) ovf <= 1'b1;
            else twp <= twp + 1'b1;
          end
          default: begin
            run_en <= wr_data[0];
            if (wr_data[1]) done <= 1'b0;
            if (wr_data[2]) ovf <= 1'b0;
          end
        endcase
      end
      if (rx_pop && rx_valid) rrp <= rrp + 1'b1;

      if (start) begin
        busy   <= 1'b1;
        trp    <= trp + 1'b1;
        e_sel  <= hd_sel;
        e_n    <= hd_n;
        e_dly  <= (cfg_dly == '0) ? DLYW'(1) : cfg_dly;
        sclk_q <= cfg_mode3;
        tx_sh  <= hd_dat << hd_sh;
        rx_sh  <= '0;
        t      <= '0;
        dv     <= '0;
        cs_n   <= ~(NSEL'(1) << hd_sel);
      end else if (busy) begin
        dv <= tick ? '0 : dv + DVW'(1);
        if (tick) t <= tn;
        if (edge_hit) begin
          sclk_q <= ~sclk_q;
          if (!sclk_q) rx_sh <= {rx_sh[DW-2:0], miso};
          else if (!first_edge) tx_sh <= tx_sh << 1;
        end
        if (rel_hit) begin
          cs_n  <= '1;
          tx_sh <= '0;
          rwp   <= rwp + 1'b1;
          if (tx_empty) done <= 1'b1;
        end
        if (fin_hit) busy <= 1'b0;
      end
    end
  end

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r7_select_steady_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sclk_q)) |-> ((cs_n != '1) && $stable(cs_n)));

  a_r5_mosi_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $rose(sclk_q)) |-> $stable(mosi));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_en && wr_addr == 2'd3 && wr_data[2])) |=> ovf);

  a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cs_n == '1));

  a_r8_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= (PW+1)'(DEPTH));

endmodule

// File: tb/tb_spi_queue_master.sv
module tb_spi_queue_master;
  localparam int DIV = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rx_data;
  logic        rx_valid, tx_full, busy, done, ovf, irq, sclk, mosi;
  logic [7:0]  cs_n;

  spi_queue_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_valid(rx_valid), .tx_full(tx_full),
    .busy(busy), .done(done), .ovf(ovf), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #2 clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, a, e, $time);
    end
  endtask

  // reference model state
  int          tq_sel[$], tq_len[$];
  logic [31:0] tq_dat[$];
  logic [31:0] rq[$];
  int  m_cdly = 0, m_cmode = 0, m_irqen = 0, m_ssel = 0, m_slen = 0, m_run = 0;
  int  m_done = 0, m_ovf = 0, m_busy = 0, m_e = 0, m_sel = 0, m_n = 4, m_dly = 1, m_mode = 0;
  logic [31:0] m_dat = '0, m_rx = '0;
  bit  started = 0;

  always @(posedge clk) begin
    int tn0, rn0, run0, h, j;
    started = 1;
    if (!rst_n) begin
      tq_sel.delete(); tq_len.delete(); tq_dat.delete(); rq.delete();
      m_cdly = 0; m_cmode = 0; m_irqen = 0; m_ssel = 0; m_slen = 0; m_run = 0;
      m_done = 0; m_ovf = 0; m_busy = 0; m_e = 0;
    end else begin
      tn0 = tq_sel.size(); rn0 = rq.size(); run0 = m_run;
      if (wr_en && wr_addr == 2'd3) begin
        if (wr_data[1]) m_done = 0;
        if (wr_data[2]) m_ovf = 0;
      end
      if (rx_pop && rn0 > 0) void'(rq.pop_front());
      if (!m_busy) begin
        if (run0 != 0 && tn0 > 0 && rn0 < 8) begin
          m_sel = tq_sel.pop_front();
          m_n   = tq_len.pop_front();
          m_n   = (m_n < 3) ? 4 : m_n + 1;
          m_dat = tq_dat.pop_front();
          m_dly = (m_cdly == 0) ? 1 : m_cdly;
          m_mode = m_cmode; m_busy = 1; m_e = 0; m_rx = '0;
        end
      end else begin
        m_e++;
        if (m_e % DIV == 0) begin
          h = m_e / DIV;
          if (h >= m_dly && h < m_dly + 2*m_n) begin
            j = h - m_dly;
            if ((m_mode == 0 && j % 2 == 0) || (m_mode == 1 && j % 2 == 1))
              m_rx = {m_rx[30:0], miso};
          end
          if (h == 2*m_dly + 2*m_n - 1) begin
            rq.push_back(m_rx);
            if (tn0 == 0) m_done = 1;
          end
          if (h == 3*m_dly + 2*m_n - 1) m_busy = 0;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_cdly = int'(wr_data[3:0]); m_cmode = int'(wr_data[4]); m_irqen = int'(wr_data[5]); end
          2'd1: begin m_ssel = int'(wr_data[2:0]); m_slen = int'(wr_data[8:4]); end
          2'd2: begin
            if (tn0 == 8) m_ovf = 1;
            else begin tq_sel.push_back(m_ssel); tq_len.push_back(m_slen); tq_dat.push_back(wr_data); end
          end
          default: m_run = int'(wr_data[0]);
        endcase
      end
    end
  end

  // per-cycle comparison plus select-window monitors
  logic [31:0] lfsr = 32'h1357_9bdf;
  bit p_act = 0; logic p_sclk = 0;
  int win = 0, edg = 0;

  always @(negedge clk) begin
    int h, ed, sh, act;
    logic [7:0] e_cs; logic e_sclk, e_mosi;
    bit cs_act;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    miso = lfsr[0];
    if (started && rst_n) begin
      if (m_busy) begin
        h   = m_e / DIV;
        act = (h < 2*m_dly + 2*m_n - 1) ? 1 : 0;
        ed  = (h >= m_dly) ? ((h - m_dly + 1 < 2*m_n) ? h - m_dly + 1 : 2*m_n) : 0;
        e_sclk = 1'(m_mode) ^ 1'(ed & 1);
        sh  = (m_mode == 1) ? ((ed > 0) ? (ed - 1) / 2 : 0) : ed / 2;
        e_mosi = (act != 0 && sh < m_n) ? m_dat[m_n - 1 - sh] : 1'b0;
        e_cs = (act != 0) ? ~(8'b1 << m_sel) : 8'hff;
      end else begin
        e_sclk = 1'(m_cmode); e_mosi = 1'b0; e_cs = 8'hff;
      end
      chk("R2 R7", "cs_n", 32'(cs_n), 32'(e_cs));
      chk("R6", "sclk", 32'(sclk), 32'(e_sclk));
      chk("R5", "mosi", 32'(mosi), 32'(e_mosi));
      chk("R2", "busy", 32'(busy), 32'(m_busy));
      chk("R3", "tx_full", 32'(tx_full), (tq_sel.size() == 8) ? 1 : 0);
      chk("R3", "ovf", 32'(ovf), 32'(m_ovf));
      chk("R9", "done", 32'(done), 32'(m_done));
      chk("R9", "irq", 32'(irq), 32'(m_done & m_irqen));
      chk("R8", "rx_valid", 32'(rx_valid), (rq.size() > 0) ? 1 : 0);
      if (rq.size() > 0) chk("R8", "rx_data", rx_data, rq[0]);

      cs_act = (cs_n !== 8'hff);
      if (cs_act && !p_act) begin win = 0; edg = 0; end
      else if (cs_act) begin
        win++;
        if (sclk !== p_sclk) begin
          edg++;
          if (edg == 1) chk("R7 R10", "lead cycles", win, m_dly * DIV);
        end
      end
      if (!cs_act && p_act) chk("R4", "edges per window", edg, 2 * m_n);
      p_act = cs_act; p_sclk = sclk;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push(input int sel, input int code, input logic [31:0] d);
    wr(2'd1, 32'((code << 4) | sel));
    wr(2'd2, d);
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!(done === 1'b1 && busy === 1'b0)) @(negedge clk);
  endtask

  task automatic drain();
    while (rx_valid === 1'b1) pop_rx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cs_n", 32'(cs_n), 32'hff);
    chk("R1", "reset sclk", 32'(sclk), 0);
    chk("R1", "reset mosi", 32'(mosi), 0);
    chk("R1", "reset flags", 32'({busy, done, ovf, irq, tx_full, rx_valid}), 0);
    rst_n = 1'b1;

    // mode 0, delay 2, irq on; 8, 17 and 18 bit frames
    wr(2'd0, 32'h22);
    push(3, 7, 32'h0000_00a5);
    push(5, 16, 32'h0001_abcd);
    push(0, 17, 32'h0002_f0f0);
    wr(2'd3, 32'h1);
    wait_done();
    chk("R9", "done at end of queue", 32'(done), 1);
    chk("R9", "irq enabled", 32'(irq), 1);
    drain();
    wr(2'd3, 32'h3);
    @(negedge clk);
    chk("R9", "done cleared", 32'(done), 0);

    // mode 3, delay 0 acts as 1, irq off; short, full and clamped lengths
    wr(2'd0, 32'h10);
    @(negedge clk);
    chk("R6", "mode 3 idle high", 32'(sclk), 1);
    push(7, 3, 32'h000f_fff5);
    push(6, 31, 32'hdead_beef);
    push(2, 2, 32'h0000_0009);
    wait_done();
    chk("R9", "irq masked", 32'(irq), 0);
    drain();
    wr(2'd3, 32'h3);

    // longest delay
    wr(2'd0, 32'h2f);
    push(1, 11, 32'h0000_0abc);
    wait_done();
    drain();
    wr(2'd3, 32'h3);

    // overflow and receive stall
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h01);
    for (int i = 0; i < 9; i++) push(i % 8, 3, 32'(i * 3 + 5));
    @(negedge clk);
    chk("R3", "overflow set", 32'(ovf), 1);
    chk("R3", "queue full", 32'(tx_full), 1);
    wr(2'd3, 32'h4);
    @(negedge clk);
    chk("R3", "overflow cleared", 32'(ovf), 0);
    chk("R3", "dropped push not stored", 32'(tx_full), 1);
    wr(2'd3, 32'h1);
    wait_done();
    wr(2'd3, 32'h3);
    push(4, 5, 32'h0000_002d);
    repeat (40) @(negedge clk);
    chk("R8", "stall while rx full", 32'(busy), 0);
    chk("R8", "no select while stalled", 32'(cs_n), 32'hff);
    pop_rx();
    wait_done();
    drain();
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule